// File: doc/BRIEF.md
# IDE PIO Cycle Timing Controller

This block turns host I/O requests into programmed-I/O read and write strobes for one legacy parallel ATA channel that carries two drives. A 16-bit timing word, loaded through a simple configuration port, turns the function on, picks which of the two legacy address windows the channel answers to, and holds a control nibble for each drive along with one shared fast-timing bank.

When a host request falls inside the active window, the block claims it. It drives the chip selects and the 3-bit register address, then asserts the matching strobe for the chosen number of clocks, then holds the recovery gap before it reports completion. The drive currently selected is tracked from writes to the drive/head register. A drive with its fast bit set uses the programmable sample point and recovery time. A drive without it uses fixed compatible timing. The selected drive can also stretch its strobe with IORDY.

The block also routes the drive interrupt to one of two host lines. It raises a prefetch hint for data-port accesses.

Top module: `ide_pio_timer`

## Requirements
- R1: While bit 15 of the timing word is 0, no I/O request is claimed (io_claim low), and no strobe, chip select or busy indication appears.
- R2: With bit 14 clear, the command window is 0x1F0..0x1F7 and the control address is 0x3F6. With bit 14 set, they are 0x170..0x177 and 0x376. A command access drives ata_cs0_n low with ata_da equal to the address offset. A control access drives ata_cs1_n low with ata_da = 6. A write uses ata_diow_n and drives io_wdata on ata_dd_out. A read uses ata_dior_n.
- R3: The interrupt input appears on irq14 when the block is enabled with bit 14 clear, and on irq15 when it is enabled with bit 14 set. The other line stays low.
- R4: Drive 0's nibble is bits 2:0 and drive 1's nibble is bits 6:4. Within each nibble, bit 0 is fast timing, bit 1 is IORDY sampling and bit 2 is prefetch.
- R5: For a drive with its fast bit set, the strobe lasts 5, 4, 3 or 2 clocks for bits 13:12 = 00, 01, 10 or 11. Recovery lasts 4, 3, 2 or 1 clocks for bits 9:8 = 00, 01, 10 or 11.
- R6: For a drive whose fast bit is clear, the strobe lasts COMPAT_STB (8) clocks and recovery lasts COMPAT_REC (12) clocks, whatever bits 13:12 and 9:8 hold.
- R7: The target drive is bit 4 of the last value written to command offset 6. The write that changes it still uses the previous selection. After reset, drive 0 is selected.
- R8: If the drive's IORDY bit is set and ata_iordy is low on the last strobe clock, the strobe stays asserted until ata_iordy is seen high, and then for one more clock. If the IORDY bit is clear, ata_iordy has no effect.
- R9: prefetch_flag is high during a cycle only when the cycle targets command offset 0 and the selected drive's prefetch bit is set.
- R10: A configuration write during a cycle leaves that cycle's timing, chip selects and address unchanged. The next cycle uses the new value.
- R11: cfg_rdata returns the timing word. Read data on ata_dd_in is captured at the end of the strobe and is presented on io_rdata when io_done pulses, which happens one clock after recovery ends.
- R12: After reset, the timing word is 0, the strobes and chip selects are high, and io_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load timing word |
| cfg_wdata | input | 16 | New timing word |
| cfg_rdata | output | 16 | Current timing word |
| io_req | input | 1 | Host I/O request |
| io_we | input | 1 | Request is a write |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 16 | Host write data |
| io_claim | output | 1 | Request hits this channel |
| io_busy | output | 1 | Cycle in progress |
| io_done | output | 1 | One-clock completion pulse |
| io_rdata | output | 16 | Captured read data |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_cs0_n | output | 1 | Command block select |
| ata_cs1_n | output | 1 | Control block select |
| ata_da | output | 3 | Drive register address |
| ata_dd_out | output | 16 | Write data to drive |
| ata_dd_oe | output | 1 | Data bus drive enable |
| ata_dd_in | input | 16 | Read data from drive |
| ata_iordy | input | 1 | Drive ready |
| ata_intrq | input | 1 | Drive interrupt |
| irq14 | output | 1 | Host interrupt, primary window |
| irq15 | output | 1 | Host interrupt, secondary window |
| prefetch_flag | output | 1 | Prefetch hint for data-port cycles |

## Verification
A configuration write and a running strobe can fall in the same clock. This is the case software creates when it reloads timing for the other drive. The bench issues a fast cycle and, on the second strobe clock, writes a timing word with different sample and recovery codes. It then judges the measured strobe and recovery widths of that cycle against the old codes and those of the next cycle against the new ones. The same counting, with ata_iordy released on a chosen strobe clock, judges the wait extension. The stability of the address and chip selects across the write is also checked on every clock.

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
  parameter int COMPAT_STB = 8,
  parameter int COMPAT_REC = 12,
  parameter logic [15:0] PRI_CMD = 16'h01F0,
  parameter logic [15:0] PRI_CTL = 16'h03F6,
  parameter logic [15:0] SEC_CMD = 16'h0170,
  parameter logic [15:0] SEC_CTL = 16'h0376
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        io_req,
  input  logic        io_we,
  input  logic [15:0] io_addr,
  input  logic [15:0] io_wdata,
  output logic        io_claim,
  output logic        io_busy,
  output logic        io_done,
  output logic [15:0] io_rdata,
  output logic        ata_dior_n,
  output logic        ata_diow_n,
  output logic        ata_cs0_n,
  output logic        ata_cs1_n,
  output logic [2:0]  ata_da,
  output logic [15:0] ata_dd_out,
  output logic        ata_dd_oe,
  input  logic [15:0] ata_dd_in,
  input  logic        ata_iordy,
  input  logic        ata_intrq,
  output logic        irq14,
  output logic        irq15,
  output logic        prefetch_flag
);
  localparam int MAXLEN = (COMPAT_STB > COMPAT_REC) ? COMPAT_STB : COMPAT_REC;
  localparam int CW = $clog2(((MAXLEN > 5) ? MAXLEN : 5) + 1);

  typedef enum logic [2:0] {S_IDLE, S_STB, S_WAIT, S_HOLD, S_REC} st_t;

  st_t            st;
  logic [15:0]    tim_q, wd_q, rd_q;
  logic           dev_q, done_q;
  logic [CW-1:0]  cnt, stb_len, rec_len;
  logic           cyc_we, cyc_cs1, cyc_iordy, cyc_pf;
  logic [2:0]     da_q;

  wire        en       = tim_q[15];
  wire        sec      = tim_q[14];
  wire [15:0] cmd_base = sec ? SEC_CMD : PRI_CMD;
  wire [15:0] ctl_addr = sec ? SEC_CTL : PRI_CTL;
  wire        hit_cmd  = io_addr[15:3] == cmd_base[15:3];
  wire        hit_ctl  = io_addr == ctl_addr;
  wire [2:0]  nib      = dev_q ? tim_q[6:4] : tim_q[2:0];
  wire [2:0]  fs3      = 3'd5 - {1'b0, tim_q[13:12]};
  wire [2:0]  fr3      = 3'd4 - {1'b0, tim_q[9:8]};
  wire        active   = st != S_IDLE;
  wire        strobe   = (st == S_STB) || (st == S_WAIT) || (st == S_HOLD);

  assign io_claim = io_req && en && (hit_cmd || hit_ctl);
  wire   accept   = io_claim && (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tim_q     <= '0;
      wd_q      <= '0;
      rd_q      <= '0;
      dev_q     <= 1'b0;
      done_q    <= 1'b0;
      cnt       <= '0;
      stb_len   <= '0;
      rec_len   <= '0;
      cyc_we    <= 1'b0;
      cyc_cs1   <= 1'b0;
      cyc_iordy <= 1'b0;
      cyc_pf    <= 1'b0;
      da_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we) tim_q <= cfg_wdata;
      case (st)
        S_IDLE: if (accept) begin
          st        <= S_STB;
          cnt       <= CW'(1);
          cyc_we    <= io_we;
          cyc_cs1   <= !hit_cmd;
          da_q      <= hit_cmd ? io_addr[2:0] : 3'd6;
          wd_q      <= io_wdata;
          cyc_iordy <= nib[1];
          cyc_pf    <= hit_cmd && (io_addr[2:0] == 3'd0) && nib[2];
          stb_len   <= nib[0] ? CW'(fs3) : CW'(COMPAT_STB);
          rec_len   <= nib[0] ? CW'(fr3) : CW'(COMPAT_REC);
          if (hit_cmd && io_we && io_addr[2:0] == 3'd6) dev_q <= io_wdata[4];
        end
        S_STB: if (cnt == stb_len) begin
          if (cyc_iordy && !ata_iordy) st <= S_WAIT;
          else begin
            st  <= S_REC;
            cnt <= CW'(1);
            if (!cyc_we) rd_q <= ata_dd_in;
          end
        end else cnt <= cnt + CW'(1);
        S_WAIT: if (ata_iordy) st <= S_HOLD;
        S_HOLD: begin
          st  <= S_REC;
          cnt <= CW'(1);
          if (!cyc_we) rd_q <= ata_dd_in;
        end
        S_REC: if (cnt == rec_len) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else cnt <= cnt + CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cfg_rdata     = tim_q;
  assign io_busy       = active;
  assign io_done       = done_q;
  assign io_rdata      = rd_q;
  assign ata_dior_n    = !(strobe && !cyc_we);
  assign ata_diow_n    = !(strobe && cyc_we);
  assign ata_cs0_n     = !(active && !cyc_cs1);
  assign ata_cs1_n     = !(active && cyc_cs1);
  assign ata_da        = active ? da_q : 3'd0;
  assign ata_dd_out    = wd_q;
  assign ata_dd_oe     = active && cyc_we;
  assign prefetch_flag = active && cyc_pf;
  assign irq14         = en && !sec && ata_intrq;
  assign irq15         = en && sec && ata_intrq;
endmodule

// File: rtl/ide_pio_timer_chk.sv
module ide_pio_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_rdata,
  input logic        io_busy,
  input logic        io_done,
  input logic        ata_dior_n,
  input logic        ata_diow_n,
  input logic        ata_cs0_n,
  input logic        ata_cs1_n,
  input logic [2:0]  ata_da,
  input logic        irq14,
  input logic        irq15,
  input logic        prefetch_flag
);
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_rdata[15] && !io_busy) |=> !io_busy); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!ata_dior_n && !ata_diow_n)); // R2
  AST_ONE_CHIP_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({!ata_cs0_n, !ata_cs1_n})); // R2
  AST_STROBE_WITHIN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (!ata_dior_n || !ata_diow_n) |-> io_busy); // R2
  AST_ONE_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n) !(irq14 && irq15)); // R3
  AST_PREFETCH_DATA_PORT: assert property (@(posedge clk) disable iff (!rst_n) prefetch_flag |-> (!ata_cs0_n && ata_da == 3'd0)); // R9
  AST_CYCLE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (io_busy && $past(io_busy)) |-> ($stable(ata_da) && $stable(ata_cs0_n) && $stable(ata_cs1_n))); // R10
  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) io_done |-> (!io_busy && $past(io_busy))); // R11
endmodule

bind ide_pio_timer ide_pio_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .io_busy(io_busy), .io_done(io_done),
  .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
  .ata_da(ata_da), .irq14(irq14), .irq15(irq15), .prefetch_flag(prefetch_flag)
);

// File: tb/ide_pio_timer_tb.sv
module ide_pio_timer_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic io_req = 0, io_we = 0;
  logic [15:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic io_claim, io_busy, io_done;
  logic ata_dior_n, ata_diow_n, ata_cs0_n, ata_cs1_n, ata_dd_oe;
  logic [2:0] ata_da;
  logic [15:0] ata_dd_out, ata_dd_in = 16'hBEEF;
  logic ata_iordy = 1, ata_intrq = 0;
  logic irq14, irq15, prefetch_flag;

  int checks = 0, fails = 0;
  int g_stb, g_rec;
  bit g_claim, g_busy_unclaimed, g_cs0, g_cs1, g_wr, g_rd, g_pf;
  logic [2:0] g_da;
  logic [15:0] g_dd, g_rdata;

  always #10 clk = ~clk;

  ide_pio_timer u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [15:0] v);
    @(negedge clk); cfg_wdata = v; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run_io(input logic [15:0] a, input bit we, input logic [15:0] wd,
                        input int rel_at, input int mid_at, input logic [15:0] mid_val);
    g_stb = 0; g_rec = 0; g_claim = 0; g_busy_unclaimed = 0;
    g_cs0 = 0; g_cs1 = 0; g_wr = 0; g_rd = 0; g_pf = 0; g_da = 0; g_dd = 0;
    @(negedge clk); io_addr = a; io_we = we; io_wdata = wd; io_req = 1;
    #1 g_claim = io_claim;
    @(negedge clk); io_req = 0;
    if (!g_claim) begin
      for (int i = 0; i < 4; i++) begin
        if (io_busy || !ata_dior_n || !ata_diow_n || !ata_cs0_n || !ata_cs1_n) g_busy_unclaimed = 1;
        @(negedge clk);
      end
      return;
    end
    for (int i = 0; i < 300; i++) begin
      if (cfg_we) cfg_we = 0;
      if (io_done) begin g_rdata = io_rdata; break; end
      if (!ata_dior_n || !ata_diow_n) begin
        g_stb++;
        if (g_stb == 1) begin
          g_cs0 = !ata_cs0_n; g_cs1 = !ata_cs1_n; g_da = ata_da;
          g_wr = !ata_diow_n; g_rd = !ata_dior_n; g_pf = prefetch_flag;
          g_dd = ata_dd_oe ? ata_dd_out : 16'hxxxx;
        end
        if (g_stb == rel_at) ata_iordy = 1;
        if (g_stb == mid_at) begin cfg_wdata = mid_val; cfg_we = 1; end
      end else if (io_busy) g_rec++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cfg_rdata == 16'h0, "R12 cfg", cfg_rdata, 0);
    chk(ata_dior_n && ata_diow_n && ata_cs0_n && ata_cs1_n && !io_busy, "R12 pins",
        {ata_dior_n, ata_diow_n, ata_cs0_n, ata_cs1_n, io_busy}, 5'b11110);
  endtask

  task automatic t_disabled;
    set_cfg(16'h0003);
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(!g_claim, "R1 claim", g_claim, 0);
    chk(!g_busy_unclaimed, "R1 no cycle", g_busy_unclaimed, 0);
  endtask

  task automatic t_primary;
    set_cfg(16'h8000);
    chk(cfg_rdata == 16'h8000, "R11 readback", cfg_rdata, 16'h8000);
    run_io(16'h01F2, 1, 16'h55AA, 0, 0, 0);
    chk(g_claim && g_cs0 && !g_cs1 && g_da == 3'd2 && g_wr, "R2 cmd write", {g_cs0, g_cs1, g_wr, g_da}, 6'b101010);
    chk(g_dd == 16'h55AA, "R2 write data", g_dd, 16'h55AA);
    chk(g_stb == 8 && g_rec == 12, "R6 compat", {g_stb[15:0], g_rec[15:0]}, {16'd8, 16'd12});
    run_io(16'h03F6, 0, 0, 0, 0, 0);
    chk(g_claim && !g_cs0 && g_cs1 && g_da == 3'd6 && g_rd, "R2 ctl read", {g_cs0, g_cs1, g_rd, g_da}, 6'b011110);
    run_io(16'h0170, 0, 0, 0, 0, 0);
    chk(!g_claim && !g_busy_unclaimed, "R2 other window", g_claim, 0);
    ata_intrq = 1; #1;
    chk(irq14 && !irq15, "R3 primary irq", {irq14, irq15}, 2'b10);
    ata_intrq = 0;
  endtask

  task automatic t_secondary;
    set_cfg(16'hC000);
    run_io(16'h0177, 0, 0, 0, 0, 0);
    chk(g_claim && g_cs0 && g_da == 3'd7 && g_rd, "R2 sec cmd", {g_claim, g_cs0, g_da}, 5'b11111);
    run_io(16'h0376, 1, 16'h0004, 0, 0, 0);
    chk(g_claim && g_cs1 && g_da == 3'd6 && g_wr, "R2 sec ctl", {g_claim, g_cs1, g_da}, 5'b11110);
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(!g_claim && !g_busy_unclaimed, "R2 sec ignores primary", g_claim, 0);
    ata_intrq = 1; #1;
    chk(!irq14 && irq15, "R3 secondary irq", {irq14, irq15}, 2'b01);
    ata_intrq = 0;
  endtask

  task automatic t_fast;
    set_cfg(16'hA101);
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_stb == 3 && g_rec == 3, "R5 codes 10/01", {g_stb[15:0], g_rec[15:0]}, {16'd3, 16'd3});
    set_cfg(16'hB301);
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_stb == 2 && g_rec == 1, "R5 codes 11/11", {g_stb[15:0], g_rec[15:0]}, {16'd2, 16'd1});
    set_cfg(16'h8001);
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_stb == 5 && g_rec == 4, "R5 codes 00/00", {g_stb[15:0], g_rec[15:0]}, {16'd5, 16'd4});
    chk(g_rdata == 16'hBEEF, "R11 read data", g_rdata, 16'hBEEF);
    set_cfg(16'hB300);
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_stb == 8 && g_rec == 12, "R6 fields ignored", {g_stb[15:0], g_rec[15:0]}, {16'd8, 16'd12});
  endtask

  task automatic t_drive_sel;
    set_cfg(16'hB310);
    run_io(16'h01F6, 1, 16'h0010, 0, 0, 0);
    chk(g_stb == 8 && g_rec == 12, "R7 select write uses old drive", {g_stb[15:0], g_rec[15:0]}, {16'd8, 16'd12});
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_stb == 2 && g_rec == 1, "R4 R7 drive1 nibble", {g_stb[15:0], g_rec[15:0]}, {16'd2, 16'd1});
    run_io(16'h01F6, 1, 16'h0000, 0, 0, 0);
    chk(g_stb == 2 && g_rec == 1, "R7 deselect write uses drive1", {g_stb[15:0], g_rec[15:0]}, {16'd2, 16'd1});
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_stb == 8 && g_rec == 12, "R7 back to drive0", {g_stb[15:0], g_rec[15:0]}, {16'd8, 16'd12});
  endtask

  task automatic t_iordy;
    set_cfg(16'hA203);
    ata_iordy = 0;
    run_io(16'h01F0, 0, 0, 5, 0, 0);
    chk(g_stb == 6 && g_rec == 2, "R8 wait plus one", {g_stb[15:0], g_rec[15:0]}, {16'd6, 16'd2});
    ata_iordy = 1;
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_stb == 3, "R8 ready high", g_stb, 3);
    set_cfg(16'hA201);
    ata_iordy = 0;
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_stb == 3, "R8 sampling off", g_stb, 3);
    ata_iordy = 1;
  endtask

  task automatic t_prefetch;
    set_cfg(16'h8004);
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_pf, "R9 data port", g_pf, 1);
    run_io(16'h01F1, 0, 0, 0, 0, 0);
    chk(!g_pf, "R9 other offset", g_pf, 0);
    set_cfg(16'h8040);
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(!g_pf, "R4 R9 other drive bit", g_pf, 0);
  endtask

  task automatic t_midwrite;
    set_cfg(16'h8001);
    run_io(16'h01F0, 0, 0, 0, 2, 16'hB301);
    chk(g_stb == 5 && g_rec == 4, "R10 running cycle kept", {g_stb[15:0], g_rec[15:0]}, {16'd5, 16'd4});
    chk(cfg_rdata == 16'hB301, "R10 write landed", cfg_rdata, 16'hB301);
    run_io(16'h01F0, 0, 0, 0, 0, 0);
    chk(g_stb == 2 && g_rec == 1, "R10 next cycle new", {g_stb[15:0], g_rec[15:0]}, {16'd2, 16'd1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_primary();
    t_secondary();
    t_fast();
    t_drive_sel();
    t_iordy();
    t_prefetch();
    t_midwrite();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule